// File: doc/BRIEF.md
# Write-Masked Vector Lane Controller

This block sits at the write-back edge of a 64-bit-per-lane vector unit. It decides what reaches the destination register after a lane operation. Each operation selects a vector length of 128, 256 or 512 bits, which gives 2, 4 or 8 active lanes. The lane results arrive from the arithmetic outside the block. The controller combines them with the old destination value under an 8-bit per-lane mask, in either merging or zeroing form. It clears every bit above the active length and registers the 512-bit outcome.

Before the arithmetic runs, the block also produces the operand pattern the lanes consume. In broadcast mode, one 64-bit scalar is copied into every active lane. Otherwise the full vector source passes through lane by lane.

An operation is launched by a single-cycle `start` pulse, and `done` answers it one cycle later. There is no back-pressure. The destination is always ready to accept a result, so `start` may be raised in any cycle, including back to back, and `done` is a strobe that nothing stalls.

Top module: `vmask_lane_ctl`

## Requirements
- R1: While reset is active, and until the first `start`, `dst` is all zeros and `done` and `err` are low.
- R2: `vl_sel` selects the active lane count: 0 gives 2 lanes, 1 gives 4 lanes and 2 gives 8 lanes. Lane j occupies bits [64j+63:64j]. The cycle after a `start` pulse, `done` is high for exactly one cycle, and `dst` holds the new value.
- R3: Active lane j takes its `lane_res` slice when `mask[j]` is 1, or when `mask_en` is 0.
- R4: When `zero_mode` is 0 (merging), an active lane whose mask bit is 0 under `mask_en`=1 keeps its `old_dst` slice.
- R5: When `zero_mode` is 1 (zeroing), an active lane whose mask bit is 0 under `mask_en`=1 becomes zero.
- R6: Every `dst` bit above 64 times the active lane count is zero after a legal operation, whatever the mask, `lane_res` and `old_dst` hold.
- R7: Mask bits for lanes at or beyond the active lane count have no effect on `dst`.
- R8: When `bcast_en` is 1, each active lane of `op_src` equals `scalar_src`. When `bcast_en` is 0, each active lane equals the matching slice of `vec_src`. Lanes of `op_src` beyond the active count, or with an illegal `vl_sel`, are zero.
- R9: When `vl_sel`=3 with `start`, `err` and `done` are both high for one cycle and `dst` keeps its previous value. `err` is low after a legal operation.
- R10: Without a `start` pulse, `dst` holds its value and `done` stays low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch of a write-back |
| vl_sel | input | 2 | Vector length code (0: 128, 1: 256, 2: 512, 3: illegal) |
| mask_en | input | 1 | 1 applies `mask`, 0 writes every active lane |
| zero_mode | input | 1 | 1 zeroes masked-off lanes, 0 merges them |
| mask | input | 8 | Per-lane write mask, bit j for lane j |
| bcast_en | input | 1 | 1 replicates `scalar_src` into the operand lanes |
| scalar_src | input | 64 | Scalar used for broadcast |
| vec_src | input | 512 | Full vector operand source |
| lane_res | input | 512 | Per-lane results from the lane arithmetic |
| old_dst | input | 512 | Current destination contents |
| op_src | output | 512 | Operand pattern handed to the lane arithmetic |
| dst | output | 512 | Registered destination value |
| done | output | 1 | One-cycle strobe after each `start` |
| err | output | 1 | One-cycle strobe for an illegal length code |

## Verification
The hardest case to reach is a short vector length combined with mask bits set in the lanes above the active count and non-zero upper `old_dst` lanes. Only that combination shows whether stray mask bits, or merging, can leak data into the region that must be cleared. The stimulus table pairs the 128-bit and 256-bit lengths with masks whose upper bits are set. It runs them after full-width operations, under both merging and zeroing, with distinct per-lane data so that any misplaced lane shows. An illegal length code is then issued between legal operations, to show that the held value survives.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic [1:0] {
    VL_X2  = 2'd0,
    VL_X4  = 2'd1,
    VL_X8  = 2'd2,
    VL_BAD = 2'd3
  } vlen_e;
endpackage

// File: rtl/vmask_vl_decode.sv
module vmask_vl_decode #(
  parameter int MAX_LANES = 8,
  parameter int MIN_LANES = 2
) (
  input  logic [1:0]           vl_sel,
  output logic [MAX_LANES-1:0] lane_act,
  output logic                 vl_ok
);
  int lane_cnt;

  always_comb begin
    lane_cnt = MIN_LANES << vl_sel;
    vl_ok    = (lane_cnt <= MAX_LANES);
    for (int j = 0; j < MAX_LANES; j++) begin
      lane_act[j] = vl_ok && (j < lane_cnt);
    end
  end
endmodule

// File: rtl/vmask_src_gen.sv
module vmask_src_gen #(
  parameter int LANE_W    = 64,
  parameter int MAX_LANES = 8
) (
  input  logic                        bcast_en,
  input  logic [LANE_W-1:0]           scalar_src,
  input  logic [LANE_W*MAX_LANES-1:0] vec_src,
  input  logic [MAX_LANES-1:0]        lane_act,
  output logic [LANE_W*MAX_LANES-1:0] op_src
);
  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    // R8: inactive lanes carry no operand
    assign op_src[j*LANE_W +: LANE_W] =
      !lane_act[j] ? '0 :
      bcast_en     ? scalar_src : vec_src[j*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/vmask_lane_merge.sv
module vmask_lane_merge #(
  parameter int LANE_W    = 64,
  parameter int MAX_LANES = 8
) (
  input  logic [MAX_LANES-1:0]        lane_act,
  input  logic [MAX_LANES-1:0]        mask,
  input  logic                        mask_en,
  input  logic                        zero_mode,
  input  logic [LANE_W*MAX_LANES-1:0] lane_res,
  input  logic [LANE_W*MAX_LANES-1:0] old_dst,
  output logic [LANE_W*MAX_LANES-1:0] nxt_dst
);
  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic wr;
    assign wr = !mask_en || mask[j];
    // R6/R7: an inactive lane is cleared before its mask bit is looked at
    assign nxt_dst[j*LANE_W +: LANE_W] =
      !lane_act[j] ? '0 :
      wr           ? lane_res[j*LANE_W +: LANE_W] :
      zero_mode    ? '0 : old_dst[j*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/vmask_lane_ctl.sv
module vmask_lane_ctl
  import vmask_pkg::*;
#(
  parameter int LANE_W    = 64,
  parameter int MAX_LANES = 8,
  parameter int MIN_LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [1:0]                  vl_sel,
  input  logic                        mask_en,
  input  logic                        zero_mode,
  input  logic [MAX_LANES-1:0]        mask,
  input  logic                        bcast_en,
  input  logic [LANE_W-1:0]           scalar_src,
  input  logic [LANE_W*MAX_LANES-1:0] vec_src,
  input  logic [LANE_W*MAX_LANES-1:0] lane_res,
  input  logic [LANE_W*MAX_LANES-1:0] old_dst,
  output logic [LANE_W*MAX_LANES-1:0] op_src,
  output logic [LANE_W*MAX_LANES-1:0] dst,
  output logic                        done,
  output logic                        err
);
  localparam int DST_W = LANE_W * MAX_LANES;

  logic [MAX_LANES-1:0] lane_act;
  logic                 vl_ok;
  logic [DST_W-1:0]     nxt_dst;

  vmask_vl_decode #(.MAX_LANES(MAX_LANES), .MIN_LANES(MIN_LANES)) u_dec (
    .vl_sel  (vl_sel),
    .lane_act(lane_act),
    .vl_ok   (vl_ok)
  );

  vmask_src_gen #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_src (
    .bcast_en  (bcast_en),
    .scalar_src(scalar_src),
    .vec_src   (vec_src),
    .lane_act  (lane_act),
    .op_src    (op_src)
  );

  vmask_lane_merge #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_merge (
    .lane_act (lane_act),
    .mask     (mask),
    .mask_en  (mask_en),
    .zero_mode(zero_mode),
    .lane_res (lane_res),
    .old_dst  (old_dst),
    .nxt_dst  (nxt_dst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst  <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= start;
      err  <= start && !vl_ok;
      if (start && vl_ok) dst <= nxt_dst;
    end
  end

  // R2: every launch is answered in the next cycle
  a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R9: illegal length raises err and holds the destination
  a_r9_bad_vl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (start && vl_sel == VL_BAD) |=> (err && $stable(dst)));

  // R9: err is never seen without done
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R10: idle cycles leave the destination alone
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(dst) && !done));

  // R3: unmasked operation writes lane 0 from the lane result
  a_r3_unmasked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start && vl_sel != VL_BAD && !mask_en) |=>
      (dst[LANE_W-1:0] == $past(lane_res[LANE_W-1:0])));

  if (MAX_LANES > MIN_LANES) begin : g_upper_chk
    // R6: shortest length clears everything above it
    a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && $past(vl_sel) == VL_X2) |->
        (dst[DST_W-1:MIN_LANES*LANE_W] == '0));
  end
endmodule

// File: tb/vmask_lane_ctl_tb.sv
module vmask_lane_ctl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   vl_sel = 2'd0;
  logic         mask_en = 1'b0;
  logic         zero_mode = 1'b0;
  logic [7:0]   mask = 8'h00;
  logic         bcast_en = 1'b0;
  logic [63:0]  scalar_src = '0;
  logic [511:0] vec_src = '0;
  logic [511:0] lane_res = '0;
  logic [511:0] old_dst = '0;
  logic [511:0] op_src;
  logic [511:0] dst;
  logic         done;
  logic         err;

  int checks = 0;
  int failures = 0;

  vmask_lane_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_sel(vl_sel),
    .mask_en(mask_en), .zero_mode(zero_mode), .mask(mask),
    .bcast_en(bcast_en), .scalar_src(scalar_src), .vec_src(vec_src),
    .lane_res(lane_res), .old_dst(old_dst), .op_src(op_src),
    .dst(dst), .done(done), .err(err)
  );

  always #4 clk = ~clk;

  // {vl_sel, mask_en, zero_mode, mask}
  localparam logic [11:0] VEC [10] = '{
    {2'd2, 1'b1, 1'b0, 8'hA5},
    {2'd2, 1'b1, 1'b1, 8'h3C},
    {2'd2, 1'b0, 1'b1, 8'h00},
    {2'd1, 1'b1, 1'b0, 8'h06},
    {2'd1, 1'b1, 1'b1, 8'hF9},
    {2'd0, 1'b1, 1'b0, 8'hFE},
    {2'd0, 1'b1, 1'b1, 8'h01},
    {2'd0, 1'b0, 1'b0, 8'h00},
    {2'd1, 1'b0, 1'b0, 8'h55},
    {2'd2, 1'b1, 1'b0, 8'h00}
  };

  task automatic chk(input bit ok, input string tag,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input int idx);
    for (int j = 0; j < 8; j++) begin
      lane_res[j*64 +: 64] = {32'hC0DE_0000 | 32'(idx), 32'h0000_1000 | 32'(j)};
      old_dst[j*64 +: 64]  = {32'h01D0_0000 | 32'(idx), 32'h0000_2000 | 32'(j)};
      vec_src[j*64 +: 64]  = {32'h5EC0_0000 | 32'(idx), 32'h0000_3000 | 32'(j)};
    end
    scalar_src = {32'hB0CA_5700, 32'(idx)};
  endtask

  function automatic logic [511:0] exp_dst(input logic [1:0] vl, input logic men,
      input logic zm, input logic [7:0] m, input logic [511:0] res,
      input logic [511:0] old);
    logic [511:0] r;
    int n;
    r = '0;
    n = 2 << vl;
    for (int j = 0; j < 8; j++) begin
      if (j < n) begin
        if (!men || m[j]) r[j*64 +: 64] = res[j*64 +: 64];
        else if (!zm)     r[j*64 +: 64] = old[j*64 +: 64];
      end
    end
    return r;
  endfunction

  function automatic logic [511:0] exp_op(input logic [1:0] vl, input logic bc,
      input logic [63:0] sc, input logic [511:0] vs);
    logic [511:0] r;
    int n;
    r = '0;
    n = (vl == 2'd3) ? 0 : (2 << vl);
    for (int j = 0; j < 8; j++) begin
      if (j < n) r[j*64 +: 64] = bc ? sc : vs[j*64 +: 64];
    end
    return r;
  endfunction

  task automatic launch(input logic [1:0] vl, input logic men, input logic zm,
                        input logic [7:0] m, input logic bc, input int idx);
    @(negedge clk);
    load(idx);
    vl_sel = vl; mask_en = men; zero_mode = zm; mask = m; bcast_en = bc;
    start = 1'b1;
    #1;
    chk(op_src == exp_op(vl, bc, scalar_src, vec_src), "R8 operand pattern",
        op_src, exp_op(vl, bc, scalar_src, vec_src));
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [11:0]  v;
    logic [511:0] held;
    repeat (3) @(negedge clk);
    chk(dst == '0 && !done && !err, "R1 during reset", {dst[509:0], done, err}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dst == '0, "R1 dst after reset", dst, '0);
    chk(!done && !err, "R1 strobes after reset", {510'd0, done, err}, '0);

    for (int i = 0; i < 10; i++) begin
      v = VEC[i];
      launch(v[11:10], v[9], v[8], v[7:0], 1'(i % 2), i);
      chk(done == 1'b1, "R2 done strobe", {511'd0, done}, 512'd1);
      chk(err == 1'b0, "R9 err low on legal length", {511'd0, err}, '0);
      chk(dst == exp_dst(v[11:10], v[9], v[8], v[7:0], lane_res, old_dst),
          "R3/R4/R5/R6/R7 table dst", dst,
          exp_dst(v[11:10], v[9], v[8], v[7:0], lane_res, old_dst));
      @(negedge clk);
      chk(done == 1'b0, "R2 done one cycle", {511'd0, done}, '0);
    end

    // R7: stray upper mask bits under 128-bit length, zeroing then merging
    launch(2'd0, 1'b1, 1'b1, 8'hFC, 1'b0, 40);
    chk(dst == '0, "R7 upper mask ignored zeroing", dst, '0);
    launch(2'd0, 1'b1, 1'b0, 8'hFC, 1'b0, 41);
    chk(dst == exp_dst(2'd0, 1'b1, 1'b0, 8'hFC, lane_res, old_dst),
        "R7 upper mask ignored merging", dst,
        exp_dst(2'd0, 1'b1, 1'b0, 8'hFC, lane_res, old_dst));

    // R6: full write, then 256-bit write must clear upper half
    launch(2'd2, 1'b0, 1'b0, 8'h00, 1'b0, 42);
    launch(2'd1, 1'b1, 1'b0, 8'hF0, 1'b1, 43);
    chk(dst[511:256] == '0, "R6 upper half cleared", dst, {256'd0, dst[255:0]});

    // R9: illegal length
    held = dst;
    launch(2'd3, 1'b0, 1'b0, 8'hFF, 1'b1, 50);
    chk(done && err, "R9 err with done", {510'd0, done, err}, 512'd3);
    chk(dst == held, "R9 dst unchanged", dst, held);

    // R10: idle with changing inputs
    @(negedge clk);
    load(60); vl_sel = 2'd2; mask_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(dst == held, "R10 dst holds without start", dst, held);
    chk(!done, "R10 done low without start", {511'd0, done}, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule